// File: doc/BRIEF.md
# I2C Output Port Group with Pin Readback

This block is an I2C slave that owns eight push-pull output pins (numbered 8 to 15 at board level) and answers at one fixed 7-bit address. A write transfer places each data byte in an output latch that drives the pins. A read transfer returns the levels measured on the pins themselves, not the latch contents. A pin that an external driver pulls away from its programmed value therefore reads back at the level it really has.

The block runs on a fast system clock and oversamples SCL and SDA through two-flop synchronizers. It detects START and STOP, shifts the address and data bytes in and out MSB first, and pulls SDA low through `sda_oe` to acknowledge a byte or to send a zero bit. The readback inputs pass through their own two-flop synchronizer. They are sampled at the rising SCL edge of every acknowledge bit that comes before a read byte: the address ACK for the first byte, and each master ACK after that.

Top module: `i2c_outport`

## Requirements
- R1: After reset `port_o` is 8'hFF and `sda_oe` is 0.
- R2: The block acknowledges only an address byte whose upper seven bits equal `ADDR` (default 7'h5D); bit 0 selects write (0) or read (1). For any other address it never drives SDA, and `port_o` does not change, until the next START.
- R3: In a write, every data byte is acknowledged. `port_o` takes the byte at the SCL falling edge that begins its ACK bit. Any number of bytes may follow one address, and each one replaces the last.
- R4: `port_o` changes only while the block is acknowledging a write data byte.
- R5: In a read, the first byte is the pin level sampled during the address ACK bit. It is sent MSB first, with a 0 bit driven low and a 1 bit released.
- R6: Read data comes from `pin_i`, not from the latch. A pin forced away from its latched value reads back at its forced level, and the latch is left unchanged.
- R7: When the master ACKs a read byte, `pin_i` is sampled again during that ACK bit, and the new value is sent as the next byte.
- R8: A master NACK ends the read. After it the block releases SDA and drives nothing more until the next START.
- R9: A STOP returns the block to idle from any state, and bits clocked after it without a START are ignored. A repeated START begins a new address phase, so a write followed by a repeated-START read returns the new latch value.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock level seen on the bus |
| sda_i | input | 1 | I2C data level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| pin_i | input | 8 | Levels measured on the eight output pins |
| port_o | output | 8 | Output latch driving the eight pins |

## Verification
A wrong bit count or a wrong state shows on SDA within one SCL bit period. It appears as a missing or misplaced acknowledge, or as `sda_oe` active where the master expects a released line, and the per-clock check catches it in the same system cycle. A latch written at the wrong moment or with the wrong byte shows on `port_o` within three system clocks of the SCL edge that caused it. A readback snapshot taken at the wrong moment shows up as a whole wrong byte. The bench changes the forced pin levels between snapshots so that a stale sample or a sample taken from the latch cannot match.

// File: rtl/i2c_outport.sv
module i2c_outport #(
  parameter logic [6:0] ADDR = 7'h5D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [7:0] pin_i,
  output logic [7:0] port_o
);
  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_AACK = 3'd2, S_WDAT = 3'd3,
                         S_WACK = 3'd4, S_RDAT = 3'd5, S_MACK = 3'd6;

  logic [2:0] scl_sy, sda_sy;
  logic [7:0] pin_m, pin_s;
  logic [2:0] state;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       rw, mack;
  logic       scl_s, scl_q, sda_s, sda_q;
  logic       scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      pin_m  <= '0;
      pin_s  <= '0;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
      pin_m  <= pin_i;
      pin_s  <= pin_m;
    end

  assign scl_s     = scl_sy[1];
  assign scl_q     = scl_sy[2];
  assign sda_s     = sda_sy[1];
  assign sda_q     = sda_sy[2];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      port_o <= '1;
    end else if (start_det) begin
      state <= S_ADDR;
      cnt   <= '0;
    end else if (stop_det) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_ADDR, S_WDAT:
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (state == S_ADDR) begin
              if (sh[7:1] == ADDR) begin
                state <= S_AACK;
                rw    <= sh[0];
              end else begin
                state <= S_IDLE;
              end
            end else begin
              state  <= S_WACK;
              port_o <= sh;
            end
          end
        S_AACK:
          if (scl_rise) begin
            if (rw) tx <= pin_s;
          end else if (scl_fall) begin
            state <= rw ? S_RDAT : S_WDAT;
            cnt   <= '0;
          end
        S_WACK:
          if (scl_fall) begin
            state <= S_WDAT;
            cnt   <= '0;
          end
        S_RDAT:
          if (scl_fall) begin
            tx  <= {tx[6:0], 1'b0};
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) state <= S_MACK;
          end
        S_MACK:
          if (scl_rise) begin
            mack <= ~sda_s;
            tx   <= pin_s;
          end else if (scl_fall) begin
            state <= mack ? S_RDAT : S_IDLE;
            cnt   <= '0;
          end
        default: state <= S_IDLE;
      endcase
    end

  assign sda_oe = (state == S_AACK) | (state == S_WACK) | ((state == S_RDAT) & ~tx[7]);
endmodule

// File: rtl/i2c_outport_chk.sv
module i2c_outport_chk #(
  parameter logic [6:0] ADDR = 7'h5D
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_rise,
  input logic       scl_fall,
  input logic [2:0] state,
  input logic [3:0] cnt,
  input logic [7:0] sh,
  input logic [7:0] tx,
  input logic [7:0] pin_s,
  input logic       mack,
  input logic       sda_oe,
  input logic [7:0] port_o
);
  localparam logic [2:0] S_ADDR = 3'd1, S_WDAT = 3'd3, S_WACK = 3'd4, S_MACK = 3'd6;

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R10

  AST_PORT_ON_WACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_o) |-> (sda_oe && state == S_WACK)); // R4

  AST_WR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WDAT && scl_fall && cnt == 4'd8) |=> port_o == $past(sh)); // R3

  AST_RESAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MACK && scl_rise) |=> tx == $past(pin_s)); // R7

  AST_ADDR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && scl_fall && cnt == 4'd8 && sh[7:1] != ADDR) |=> !sda_oe); // R2

  AST_NACK_END: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MACK && scl_fall && !mack) |=> !sda_oe); // R8
endmodule

bind i2c_outport i2c_outport_chk #(.ADDR(ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
  .state(state), .cnt(cnt), .sh(sh), .tx(tx), .pin_s(pin_s), .mack(mack),
  .sda_oe(sda_oe), .port_o(port_o)
);

// File: tb/i2c_outport_tb.sv
`timescale 1ns/1ps
module i2c_outport_tb;
  localparam logic [6:0] ADDR = 7'h5D;

  logic       clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [7:0] fmask = 8'h00, fval = 8'h00;
  logic [7:0] pin_i, port_o;
  logic       sda_oe, sda_bus;
  int         n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] exp_port = 8'hFF, pend = 8'hFF;
  bit         win = 0, oe_allow = 0, mon_en = 0, prev_oe = 0;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;
  assign pin_i   = (port_o & ~fmask) | (fval & fmask);

  i2c_outport #(.ADDR(ADDR)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .pin_i(pin_i), .port_o(port_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
    if (mon_en) begin
      chk(port_o == exp_port || (win && port_o == pend), "R4 port_o", port_o, exp_port);
      chk(oe_allow || !sda_oe, "R2/R8 sda_oe idle", sda_oe, 0);
      chk(!(sda_oe != prev_oe && scl), "R10 sda_oe vs scl", sda_oe, prev_oe);
    end
    prev_oe = sda_oe;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input bit b, output bit r);
    sda_m = b; wt(4);
    scl = 1'b1; wt(4);
    r = sda_bus; wt(4);
    scl = 1'b0; wt(4);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wt(4);
    scl = 1'b1; wt(8);
    sda_m = 1'b0; wt(8);
    scl = 1'b0; wt(4);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wt(4);
    scl = 1'b1; wt(8);
    sda_m = 1'b1; wt(8);
  endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input bit upd, input bit keep,
                      input string req);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) begin
        if (exp_ack) oe_allow = 1;
        if (upd) begin pend = b; win = 1; end
      end
      bit_io(b[i], r);
    end
    bit_io(1'b1, r);
    chk(!r == exp_ack, req, !r, exp_ack);
    oe_allow = keep;
    if (upd) begin exp_port = pend; win = 0; end
  endtask

  task automatic recv(input bit mack, input logic [7:0] exp, input string req);
    bit r;
    logic [7:0] d;
    oe_allow = 1;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, r);
      d[i] = r;
    end
    oe_allow = mack;
    bit_io(!mack, r);
    chk(d == exp, req, d, exp);
  endtask

  task automatic idle_bits(input int n, input string req);
    bit r;
    for (int i = 0; i < n; i++) begin
      bit_io(1'b1, r);
      chk(r == 1'b1, req, r, 1);
    end
  endtask

  initial begin
    bit r;
    wt(5);
    chk(port_o == 8'hFF, "R1 reset latch", port_o, 8'hFF);
    chk(sda_oe == 1'b0, "R1 reset sda", sda_oe, 0);
    rst_n = 1'b1; wt(4);
    mon_en = 1;

    // R2 R3: two-byte write
    do_start();
    send({ADDR, 1'b0}, 1, 0, 0, "R2 own address ack");
    send(8'h5A, 1, 1, 0, "R3 data ack 1");
    send(8'h3C, 1, 1, 0, "R3 data ack 2");
    do_stop();
    chk(port_o == 8'h3C, "R3 latch after write", port_o, 8'h3C);

    // R2: foreign address
    do_start();
    send({7'h22, 1'b0}, 0, 0, 0, "R2 foreign write no ack");
    send(8'h00, 0, 0, 0, "R2 data ignored");
    do_stop();
    chk(port_o == 8'h3C, "R2 latch untouched", port_o, 8'h3C);
    do_start();
    send({7'h5C, 1'b1}, 0, 0, 0, "R2 foreign read no ack");
    idle_bits(9, "R2 foreign read released");
    do_stop();

    // R5 R8: plain read
    do_start();
    send({ADDR, 1'b1}, 1, 0, 1, "R5 read address ack");
    recv(0, 8'h3C, "R5 first read byte");
    idle_bits(9, "R8 released after nack");
    do_stop();
    chk(sda_oe == 1'b0, "R8 idle after stop", sda_oe, 0);

    // R6 R7: forced pins and resampling
    fmask = 8'hF0; fval = 8'hA0;
    do_start();
    send({ADDR, 1'b1}, 1, 0, 1, "R6 read address ack");
    fval = 8'h50;
    recv(1, 8'hAC, "R6 forced readback");
    fmask = 8'h00;
    recv(1, 8'h5C, "R7 resampled byte 2");
    recv(0, 8'h3C, "R7 resampled byte 3");
    do_stop();
    chk(port_o == 8'h3C, "R6 latch unchanged by force", port_o, 8'h3C);

    // R9: repeated start from write to read
    do_start();
    send({ADDR, 1'b0}, 1, 0, 0, "R9 write address");
    send(8'h81, 1, 1, 0, "R9 write byte");
    do_start();
    send({ADDR, 1'b1}, 1, 0, 1, "R9 repeated start read address");
    recv(0, 8'h81, "R9 read after repeated start");
    do_stop();

    // R9: stop mid address, then bits with no start
    do_start();
    bit_io(1'b1, r); bit_io(1'b0, r); bit_io(1'b1, r);
    do_stop();
    for (int i = 7; i >= 0; i--) bit_io(ADDR[i > 0 ? i - 1 : 0] & (i > 0), r);
    idle_bits(2, "R9 no ack without start");
    do_stop();
    chk(port_o == 8'h81, "R9 latch kept", port_o, 8'h81);

    // R3: long burst
    do_start();
    send({ADDR, 1'b0}, 1, 0, 0, "R3 burst address");
    send(8'h11, 1, 1, 0, "R3 burst 1");
    send(8'h22, 1, 1, 0, "R3 burst 2");
    send(8'h33, 1, 1, 0, "R3 burst 3");
    send(8'h00, 1, 1, 0, "R3 burst 4");
    do_stop();
    chk(port_o == 8'h00, "R3 burst final", port_o, 8'h00);

    wt(10);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule